// File: doc/BRIEF.md
# Completion Interrupt Moderator

This block sits between a DMA engine's per-packet completion strobe and the interrupt line for one traffic direction (receive or transmit). Rather than raising an interrupt for every completion, it holds completions back and releases a single done interrupt once one of two timers expires. The burst timer limits how long any batch of completions may wait. The idle timer fires when the completion stream goes quiet for a programmed gap. Each timer has its own control word and its own threshold. Each can count core clock cycles or pulses of an external microsecond tick.

A second, independent output warns software early when a buffer fill level reaches a limit. This lets software start draining the ring while a done interrupt is still being held. The warning never waits on the moderation timers. With both timers inactive the block is transparent: every completion turns into a done pulse.

Top module: `cmpl_irq_moderator`

## Requirements
- R1: After reset both outputs are low, both timers are disabled with zero thresholds, and the block is in pass-through mode.
- R2: While neither timer is active, done_irq_o is high for exactly the cycle after each clock edge that samples cmpl_i high, including on back-to-back completions.
- R3: Control words use bit 0 = clear, bit 1 = enable, bit 2 = external tick select. A write with bit 0 set disables the timer, drops tick select and zeroes its count, whatever the other bits hold.
- R4: The burst timer with threshold T counting clock cycles starts at the first completion sampled at edge k after a release and releases at edge k+T+1, even while completions keep arriving. A completion sampled on the release edge is covered by that release.
- R5: The idle timer with threshold T restarts on every completion and releases at edge j+T+1, where j is the edge of the last completion.
- R6: With both timers active, whichever expires first releases, and the release resets both counts.
- R7: With tick select set, a timer advances only on edges that sample usec_tick_i high.
- R8: Every done pulse lasts one cycle, follows a completion, and clears the pending state. No done pulse arises while nothing is pending.
- R9: A timer that is enabled but has a zero threshold holds nothing back.
- R10: early_irq_o pulses for one cycle after the first edge that samples fill_i >= fill_limit_i following an edge that sampled it below, independent of any held done interrupt.
- R11: If the timers become inactive while completions are pending, the done pulse is released at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmpl_i | input | 1 | One completion per sampled high cycle |
| usec_tick_i | input | 1 | External microsecond tick, one cycle wide |
| brst_ctl_we_i | input | 1 | Burst control write strobe |
| brst_ctl_i | input | 3 | Burst control word (clear, enable, tick select) |
| brst_thr_we_i | input | 1 | Burst threshold write strobe |
| brst_thr_i | input | THR_W | Burst threshold in ticks |
| idle_ctl_we_i | input | 1 | Idle control write strobe |
| idle_ctl_i | input | 3 | Idle control word (clear, enable, tick select) |
| idle_thr_we_i | input | 1 | Idle threshold write strobe |
| idle_thr_i | input | THR_W | Idle threshold in ticks |
| fill_i | input | FILL_W | Current buffer fill level |
| fill_limit_i | input | FILL_W | Fill level that triggers the early warning |
| done_irq_o | output | 1 | Moderated done interrupt pulse |
| early_irq_o | output | 1 | Early-warning interrupt pulse |

## Verification
On every cycle the assertions check several properties of the done and early pulses. A done pulse must trace back to a completion or to pending work, and it must leave nothing pending. Pass-through and draining must respond within one edge once the timers are inactive. The early warning must be a single-cycle edge on a fill level that really reached the limit. Only the bench scenarios can show the exact release cycles. These cover burst expiry under a steady stream, idle restarts, the race between both timers, counting on external ticks, and the effect of clear-dominant control writes. Each is checked against cycle numbers computed from the programmed thresholds.

// File: rtl/cim_pkg.sv
// Shared definitions for the completion interrupt moderator.
// Assumes control words are three bits wide with a fixed field layout.
package cim_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Width of a timer control word.
    localparam int CTL_W = 3;

    // Control word as written: bit 2 tick select, bit 1 enable, bit 0 clear.
    typedef struct packed {
        logic tsel;
        logic en;
        logic clr;
    } cim_ctl_t;

    // Stored configuration of one timer.
    typedef struct packed {
        logic en;
        logic tsel;
    } cim_cfg_t;
endpackage

// File: rtl/cim_timer.sv
// One moderation timer: control and threshold registers plus a saturating
// counter. IDLE_MODE=1 restarts the count on each completion (idle gap);
// IDLE_MODE=0 lets it run from the first pending cycle (burst limit).
// Assumes the release input resets the count in the cycle it is high.
module cim_timer #(
    parameter int THR_W     = 16,
    parameter bit IDLE_MODE = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ctl_we,
    input  logic [cim_pkg::CTL_W-1:0] ctl_wdata,
    input  logic                     thr_we,
    input  logic [THR_W-1:0]         thr_wdata,
    input  logic                     usec_tick,
    input  logic                     pending,
    input  logic                     cmpl,
    input  logic                     release_i,
    output logic                     active_o,
    output logic                     expired_o
);
    timeunit 1ns;
    timeprecision 1ps;
    import cim_pkg::*;

    cim_ctl_t          wr_ctl;
    cim_cfg_t          cfg_q;
    logic [THR_W-1:0]  thr_q;
    logic [THR_W-1:0]  cnt_q;
    logic              tick;
    logic              reached;
    logic              restart;
    logic              wipe;

    assign wr_ctl = cim_ctl_t'(ctl_wdata);

    // Control register: a clear write dominates and stops the timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (ctl_we) begin
            if (wr_ctl.clr) begin
                cfg_q <= '0;
            end else begin
                cfg_q.en   <= wr_ctl.en;
                cfg_q.tsel <= wr_ctl.tsel;
            end
        end
    end

    // Threshold register, in tick units.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q <= '0;
        end else if (thr_we) begin
            thr_q <= thr_wdata;
        end
    end

    // Tick source selection: core clock or external microsecond pulse.
    assign tick     = cfg_q.tsel ? usec_tick : 1'b1;
    assign active_o = cfg_q.en && (thr_q != '0);
    assign reached  = (cnt_q >= thr_q);

    // Variant selection: idle timers restart and hold off on a completion.
    generate
        if (IDLE_MODE) begin : g_idle
            assign restart = cmpl;
        end else begin : g_burst
            assign restart = 1'b0;
        end
    endgenerate

    assign wipe      = (ctl_we && wr_ctl.clr) || release_i || restart || !active_o;
    assign expired_o = active_o && pending && reached && !restart;

    // Counter: zeroed on clear, release, restart or inactivity; else counts ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wipe) begin
            cnt_q <= '0;
        end else if (pending && tick && !reached) begin
            cnt_q <= cnt_q + THR_W'(1);
        end
    end
endmodule

// File: rtl/cim_fill_watch.sv
// Early-warning detector: one-cycle pulse when the fill level first reaches
// the limit after having been below it. Assumes fill and limit are unsigned.
module cim_fill_watch #(
    parameter int FILL_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FILL_W-1:0] fill,
    input  logic [FILL_W-1:0] limit,
    output logic              warn_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic above;
    logic above_q;
    logic warn_q;

    assign above = (fill >= limit);

    // Edge detection on the above-limit condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            above_q <= 1'b0;
            warn_q  <= 1'b0;
        end else begin
            above_q <= above;
            warn_q  <= above && !above_q;
        end
    end

    assign warn_o = warn_q;
endmodule

// File: rtl/cmpl_irq_moderator.sv
// Completion interrupt moderator for one direction. Holds completions
// pending until the burst or idle timer expires, then emits a one-cycle
// done pulse; passes completions straight through when neither timer is
// active. The early-warning path is independent of the moderation.
// Assumes cmpl_i is one completion per high cycle.
module cmpl_irq_moderator #(
    parameter int THR_W  = 16,
    parameter int FILL_W = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmpl_i,
    input  logic                      usec_tick_i,
    input  logic                      brst_ctl_we_i,
    input  logic [cim_pkg::CTL_W-1:0] brst_ctl_i,
    input  logic                      brst_thr_we_i,
    input  logic [THR_W-1:0]          brst_thr_i,
    input  logic                      idle_ctl_we_i,
    input  logic [cim_pkg::CTL_W-1:0] idle_ctl_i,
    input  logic                      idle_thr_we_i,
    input  logic [THR_W-1:0]          idle_thr_i,
    input  logic [FILL_W-1:0]         fill_i,
    input  logic [FILL_W-1:0]         fill_limit_i,
    output logic                      done_irq_o,
    output logic                      early_irq_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic brst_active, brst_exp;
    logic idle_active, idle_exp;
    logic moderating;
    logic release_w;
    logic pending_q;
    logic done_q;

    cim_timer #(.THR_W(THR_W), .IDLE_MODE(1'b0)) u_brst (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(brst_ctl_we_i), .ctl_wdata(brst_ctl_i),
        .thr_we(brst_thr_we_i), .thr_wdata(brst_thr_i),
        .usec_tick(usec_tick_i), .pending(pending_q), .cmpl(cmpl_i),
        .release_i(release_w), .active_o(brst_active), .expired_o(brst_exp)
    );

    cim_timer #(.THR_W(THR_W), .IDLE_MODE(1'b1)) u_idle (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(idle_ctl_we_i), .ctl_wdata(idle_ctl_i),
        .thr_we(idle_thr_we_i), .thr_wdata(idle_thr_i),
        .usec_tick(usec_tick_i), .pending(pending_q), .cmpl(cmpl_i),
        .release_i(release_w), .active_o(idle_active), .expired_o(idle_exp)
    );

    cim_fill_watch #(.FILL_W(FILL_W)) u_fill (
        .clk(clk), .rst_n(rst_n),
        .fill(fill_i), .limit(fill_limit_i), .warn_o(early_irq_o)
    );

    // Release decision: a timer expiry, or pass-through / drain when idle.
    assign moderating = brst_active || idle_active;
    assign release_w  = brst_exp || idle_exp || (!moderating && (cmpl_i || pending_q));

    // Pending flag: set by a moderated completion, cleared by a release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
        end else if (release_w) begin
            pending_q <= 1'b0;
        end else if (cmpl_i && moderating) begin
            pending_q <= 1'b1;
        end
    end

    // Registered done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= release_w;
        end
    end

    assign done_irq_o = done_q;
endmodule

// File: rtl/cmpl_irq_moderator_chk.sv
// Assertion checker for the completion interrupt moderator, bound to the top.
module cmpl_irq_moderator_chk #(
    parameter int FILL_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmpl_i,
    input logic [FILL_W-1:0] fill_i,
    input logic [FILL_W-1:0] fill_limit_i,
    input logic              done_irq_o,
    input logic              early_irq_o,
    input logic              pending,
    input logic              mod_active
);
    timeunit 1ns;
    timeprecision 1ps;

    // R8: a done pulse needs a completion or pending work on the prior edge.
    p_done_has_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq_o |-> $past(cmpl_i || pending));

    // R8: a release leaves nothing pending.
    p_release_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq_o |-> !pending);

    // R8: no work, no done pulse.
    p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending && !cmpl_i) |=> !done_irq_o);

    // R2: pass-through when no timer is active.
    p_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mod_active && cmpl_i) |=> done_irq_o);

    // R11: pending work drains once the timers go inactive.
    p_drain_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!mod_active && pending) |=> done_irq_o);

    // R10: early pulse is one cycle wide.
    p_early_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        early_irq_o |=> !early_irq_o);

    // R10: early pulse only when the limit was reached.
    p_early_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        early_irq_o |-> $past(fill_i >= fill_limit_i));
endmodule

bind cmpl_irq_moderator cmpl_irq_moderator_chk #(.FILL_W(FILL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmpl_i(cmpl_i),
    .fill_i(fill_i), .fill_limit_i(fill_limit_i),
    .done_irq_o(done_irq_o), .early_irq_o(early_irq_o),
    .pending(pending_q), .mod_active(moderating)
);

// File: tb/cmpl_irq_moderator_test.sv
module cmpl_irq_moderator_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int THR_W  = 16;
    localparam int FILL_W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmpl_i = 1'b0, usec_tick_i = 1'b0;
    logic brst_ctl_we_i = 1'b0, brst_thr_we_i = 1'b0;
    logic idle_ctl_we_i = 1'b0, idle_thr_we_i = 1'b0;
    logic [2:0] brst_ctl_i = '0, idle_ctl_i = '0;
    logic [THR_W-1:0] brst_thr_i = '0, idle_thr_i = '0;
    logic [FILL_W-1:0] fill_i = '0, fill_limit_i = 12'd100;
    logic done_irq_o, early_irq_o;

    int cyc = 0;
    int n_cmp = 0, n_bad = 0;
    bit finished = 0;
    int exp_done[$];
    string tag_done[$];
    int exp_early[$];
    string tag_early[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cmpl_irq_moderator #(.THR_W(THR_W), .FILL_W(FILL_W)) uut (
        .clk(clk), .rst_n(rst_n), .cmpl_i(cmpl_i), .usec_tick_i(usec_tick_i),
        .brst_ctl_we_i(brst_ctl_we_i), .brst_ctl_i(brst_ctl_i),
        .brst_thr_we_i(brst_thr_we_i), .brst_thr_i(brst_thr_i),
        .idle_ctl_we_i(idle_ctl_we_i), .idle_ctl_i(idle_ctl_i),
        .idle_thr_we_i(idle_thr_we_i), .idle_thr_i(idle_thr_i),
        .fill_i(fill_i), .fill_limit_i(fill_limit_i),
        .done_irq_o(done_irq_o), .early_irq_o(early_irq_o)
    );

    task automatic check(bit ok, string tag, string what, int act, int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    task automatic push_done(int c, string t);
        exp_done.push_back(c);
        tag_done.push_back(t);
    endtask

    task automatic push_early(int c, string t);
        exp_early.push_back(c);
        tag_early.push_back(t);
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_cmpl();
        cmpl_i = 1'b1;
        @(negedge clk);
        cmpl_i = 1'b0;
    endtask

    task automatic wr_brst(logic [2:0] c, int t);
        brst_ctl_we_i = 1'b1; brst_ctl_i = c;
        brst_thr_we_i = 1'b1; brst_thr_i = THR_W'(t);
        @(negedge clk);
        brst_ctl_we_i = 1'b0; brst_thr_we_i = 1'b0;
    endtask

    task automatic wr_idle(logic [2:0] c, int t);
        idle_ctl_we_i = 1'b1; idle_ctl_i = c;
        idle_thr_we_i = 1'b1; idle_thr_i = THR_W'(t);
        @(negedge clk);
        idle_ctl_we_i = 1'b0; idle_thr_we_i = 1'b0;
    endtask

    // Monitor: pops expected pulse cycles and compares with observed pulses.
    always @(negedge clk) begin : monitor
        int e;
        string t;
        if (rst_n) begin
            if (done_irq_o) begin
                if (exp_done.size() == 0) begin
                    check(1'b0, "R8", "unexpected done pulse at cycle", cyc, -1);
                end else begin
                    e = exp_done.pop_front();
                    t = tag_done.pop_front();
                    check(e == cyc, t, "done pulse cycle", cyc, e);
                end
            end
            if (early_irq_o) begin
                if (exp_early.size() == 0) begin
                    check(1'b0, "R10", "unexpected early pulse at cycle", cyc, -1);
                end else begin
                    e = exp_early.pop_front();
                    t = tag_early.pop_front();
                    check(e == cyc, t, "early pulse cycle", cyc, e);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R8: watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : driver
        int d;
        int w;
        wait_n(3);
        check(done_irq_o == 1'b0, "R1", "done during reset", done_irq_o, 0);
        check(early_irq_o == 1'b0, "R1", "early during reset", early_irq_o, 0);
        rst_n = 1'b1;
        wait_n(2);

        // R1 / R2: pass-through from reset defaults, single and back-to-back.
        d = cyc; push_done(d + 1, "R1");
        pulse_cmpl();
        wait_n(2);
        d = cyc; push_done(d + 1, "R2"); push_done(d + 2, "R2");
        cmpl_i = 1'b1; wait_n(2); cmpl_i = 1'b0;
        wait_n(3);

        // R9: enabled with zero thresholds still passes through.
        wr_brst(3'b010, 0); wr_idle(3'b010, 0);
        d = cyc; push_done(d + 1, "R9");
        pulse_cmpl();
        wait_n(3);

        // R3: clear bit dominates an enable in the same write.
        wr_brst(3'b011, 5); wr_idle(3'b001, 0);
        d = cyc; push_done(d + 1, "R3");
        pulse_cmpl();
        wait_n(3);

        // R4: burst limit under a continuous stream of 12 completions.
        wr_brst(3'b010, 5);
        d = cyc; push_done(d + 7, "R4"); push_done(d + 14, "R4");
        cmpl_i = 1'b1; wait_n(12); cmpl_i = 1'b0;
        wait_n(10);

        // R5: idle gap restarts on each completion.
        wr_brst(3'b001, 0); wr_idle(3'b010, 4);
        d = cyc; push_done(d + 10, "R5");
        pulse_cmpl(); wait_n(1);
        pulse_cmpl(); wait_n(1);
        pulse_cmpl();
        wait_n(12);

        // R6: both active; idle wins on a lone completion, burst on a stream.
        wr_brst(3'b010, 6); wr_idle(3'b010, 3);
        d = cyc; push_done(d + 5, "R6");
        pulse_cmpl();
        wait_n(10);
        d = cyc; push_done(d + 8, "R6"); push_done(d + 13, "R6");
        for (int i = 0; i < 5; i++) begin
            pulse_cmpl();
            wait_n(1);
        end
        wait_n(15);

        // R7: burst counting on external ticks only.
        wr_idle(3'b001, 0); wr_brst(3'b110, 2);
        d = cyc; push_done(d + 9, "R7");
        pulse_cmpl();
        wait_n(2);
        usec_tick_i = 1'b1; wait_n(1); usec_tick_i = 1'b0;
        wait_n(3);
        usec_tick_i = 1'b1; wait_n(1); usec_tick_i = 1'b0;
        wait_n(6);

        // R11 / R3: clear write while pending drains at once; later run is normal.
        wr_brst(3'b010, 8);
        pulse_cmpl();
        wait_n(2);
        w = cyc; push_done(w + 2, "R11");
        wr_brst(3'b001, 8);
        wait_n(5);
        wr_brst(3'b010, 3);
        d = cyc; push_done(d + 5, "R3");
        pulse_cmpl();
        wait_n(8);

        // R10: early warning while a done pulse is held back.
        wr_brst(3'b010, 20);
        d = cyc; push_done(d + 22, "R10");
        pulse_cmpl();
        push_early(cyc + 1, "R10");
        fill_i = 12'd100;
        wait_n(3);
        fill_i = 12'd150;
        wait_n(3);
        fill_i = 12'd99;
        wait_n(2);
        push_early(cyc + 1, "R10");
        fill_i = 12'd120;
        wait_n(3);
        fill_i = 12'd0;
        wait_n(25);

        check(exp_done.size() == 0, "R8", "done pulses still expected", exp_done.size(), 0);
        check(exp_early.size() == 0, "R10", "early pulses still expected", exp_early.size(), 0);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule